// File: doc/BRIEF.md
# Framebuffer Control and Status Register Block

This block is the small byte-wide register file that sits beside a framebuffer controller. It holds the following registers:

- A control byte whose top bit arms the end-of-frame interrupt.
- A status byte that combines a sticky interrupt-pending flag with fixed board-identity bits.
- A bank of fourteen general read/write bytes that software uses for display timing values.

Reads are combinational from the current address. Writes and the frame pulse take effect on the rising clock edge.

The interrupt path is a two-state machine. In `IRQ_IDLE` the line is low. The transition *arm-and-fire* moves it to `IRQ_PENDING` when `frame_end` arrives while the control enable bit is set. In `IRQ_PENDING` the line is high. The transition *acknowledge* returns it to `IRQ_IDLE` on any write to the status offset. Every other input keeps the current state. Reset forces `IRQ_IDLE`.

Top module: `fbctl_regfile`

## Requirements
- R1: While `rst_n` is low and after it rises, `irq_out` is 0, the control byte reads 0x00, status reads 0x61, and every bank byte reads 0x00.
- R2: Offset 0x10 is the control byte. A write stores all 8 bits, and a read returns them.
- R3: Offsets 0x12 to 0x1F are fourteen independent bytes. Each one reads back the last value written to that offset only.
- R4: A status read at offset 0x11 returns the pending flag in bit 7, OR-ed with the constant 0x61. The constant is 0x60 for the monitor code and 0x01 for the colour-board flag. Writes never alter these constant bits.
- R5: A `frame_end` pulse sampled while control bit 7 is 1 sets pending. From the next edge on, `irq_out` is high and status reads 0xE1. The enable value used is the one held before any control write in that same cycle.
- R6: A `frame_end` pulse while control bit 7 is 0 leaves `irq_out` low and status at 0x61.
- R7: A write of any value to 0x11 while pending clears pending and lowers `irq_out` at the next edge. This holds even when `frame_end` with enable set arrives in the same cycle.
- R8: Once pending, `irq_out` stays high across further frame pulses and across a control write that clears bit 7, until it is acknowledged.
- R9: Offsets 0x00 to 0x0F read 0x00. Writes to them change no register.
- R10: A status write while not pending has no effect. A `frame_end` with enable set in the same cycle still sets pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (5) | Byte offset of the access |
| bus_wr | input | 1 | Write strobe for `bus_wdata` at `bus_addr` |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| frame_end | input | 1 | One-cycle end-of-frame pulse |
| irq_out | output | 1 | Level interrupt, high while pending |

## Verification
Writes, frame pulses and acknowledges are registered once, so their effect on `irq_out` and on read data is due one rising edge after the cycle they are presented in. Read data itself is due in the same cycle as the address. The bench drives every input on the falling edge and compares `irq_out` and `bus_rdata` against its reference model shortly after that. This places the check before the next rising edge, so each check sees exactly the state built by the edges already passed. The model applies each cycle's inputs at the rising edge. It uses the pre-edge enable value, so the same-cycle cases in R5, R7 and R10 are predicted without any look at the design.

// File: rtl/fbctl_pkg.sv
package fbctl_pkg;
    localparam int DATA_W        = 8;
    localparam int CTRL_OFF      = 'h10;
    localparam int STAT_OFF      = 'h11;
    localparam int BANK_BASE     = 'h12;
    localparam int BANK_COUNT    = 14;
    localparam int BANK_IDX_W    = $clog2(BANK_COUNT);
    localparam int CTRL_IE_BIT   = 7;
    localparam int STAT_PEND_BIT = 7;
    localparam logic [DATA_W-1:0] STAT_FIXED = 8'h61;

    typedef enum logic {
        IRQ_IDLE    = 1'b0,
        IRQ_PENDING = 1'b1
    } irq_state_e;
endpackage

// File: rtl/fbctl_decode.sv
module fbctl_decode
    import fbctl_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic                  sel_ctrl,
    output logic                  sel_stat,
    output logic                  sel_bank,
    output logic [BANK_IDX_W-1:0] bank_idx
);
    logic [31:0] addr_ext;
    logic [31:0] bank_off;

    always_comb begin
        addr_ext = 32'(addr);
        bank_off = addr_ext - 32'(BANK_BASE);
        sel_ctrl = (addr_ext == 32'(CTRL_OFF));
        sel_stat = (addr_ext == 32'(STAT_OFF));
        sel_bank = (addr_ext >= 32'(BANK_BASE)) &&
                   (addr_ext <  32'(BANK_BASE + BANK_COUNT));
        bank_idx = BANK_IDX_W'(bank_off);
    end
endmodule

// File: rtl/fbctl_timing_bank.sv
module fbctl_timing_bank
    import fbctl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  sel,
    input  logic [BANK_IDX_W-1:0] idx,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata
);
    logic [DATA_W-1:0] cells [BANK_COUNT];

    for (genvar g = 0; g < BANK_COUNT; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cells[g] <= '0;
            end else if (wr_en && sel && (idx == BANK_IDX_W'(g))) begin
                cells[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < BANK_COUNT; i++) begin
            if (sel && (idx == BANK_IDX_W'(i))) begin
                rdata = cells[i];
            end
        end
    end
endmodule

// File: rtl/fbctl_irq_fsm.sv
module fbctl_irq_fsm
    import fbctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_end,
    input  logic int_en,
    input  logic stat_wr,
    output logic pending
);
    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: begin
                if (frame_end && int_en) begin
                    state_d = IRQ_PENDING;
                end
            end
            IRQ_PENDING: begin
                if (stat_wr) begin
                    state_d = IRQ_IDLE;
                end
            end
            default: state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        pending = (state_q == IRQ_PENDING);
    end
endmodule

// File: rtl/fbctl_regfile.sv
module fbctl_regfile
    import fbctl_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              frame_end,
    output logic              irq_out
);
    logic                  sel_ctrl;
    logic                  sel_stat;
    logic                  sel_bank;
    logic [BANK_IDX_W-1:0] bank_idx;
    logic [DATA_W-1:0]     ctrl_q;
    logic [DATA_W-1:0]     bank_rdata;
    logic                  int_en;
    logic                  pending;

    fbctl_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr     (bus_addr),
        .sel_ctrl (sel_ctrl),
        .sel_stat (sel_stat),
        .sel_bank (sel_bank),
        .bank_idx (bank_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (bus_wr && sel_ctrl) begin
            ctrl_q <= bus_wdata;
        end
    end

    assign int_en = ctrl_q[CTRL_IE_BIT];

    fbctl_timing_bank u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr),
        .sel   (sel_bank),
        .idx   (bank_idx),
        .wdata (bus_wdata),
        .rdata (bank_rdata)
    );

    fbctl_irq_fsm u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .int_en    (int_en),
        .stat_wr   (bus_wr && sel_stat),
        .pending   (pending)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) begin
            bus_rdata = ctrl_q;
        end else if (sel_stat) begin
            bus_rdata = STAT_FIXED;
            bus_rdata[STAT_PEND_BIT] = pending;
        end else if (sel_bank) begin
            bus_rdata = bank_rdata;
        end
    end

    assign irq_out = pending;
endmodule

// File: rtl/fbctl_regfile_chk.sv
module fbctl_regfile_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_rdata,
    input logic              frame_end,
    input logic              irq_out,
    input logic              int_en
);
    logic [31:0] a_ext;
    logic        ack;
    assign a_ext = 32'(bus_addr);
    assign ack   = bus_wr && (a_ext == 32'h11);

    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> !irq_out);

    a_r5_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_out && frame_end && int_en) |=> irq_out);

    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_out && !(frame_end && int_en)) |=> !irq_out);

    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && ack) |=> !irq_out);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !ack) |=> irq_out);

    a_r4_status_view: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ext == 32'h11) |-> (bus_rdata == {irq_out, 7'h61}));

    a_r9_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ext < 32'h10) |-> (bus_rdata == 8'h00));
endmodule

bind fbctl_regfile fbctl_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .frame_end (frame_end),
    .irq_out   (irq_out),
    .int_en    (int_en)
);

// File: tb/fbctl_regfile_tb_top.sv
`timescale 1ns/1ps
module fbctl_regfile_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       frame_end = 1'b0;
    logic       irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int m_ctrl = 0;
    int m_pend = 0;
    int m_bank [14];

    always #2 clk = ~clk;

    fbctl_regfile #(.ADDR_W(5)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .frame_end (frame_end),
        .irq_out   (irq_out)
    );

    function automatic int model_read(int a);
        if (a == 'h10) return m_ctrl;
        if (a == 'h11) return 'h61 | (m_pend ? 'h80 : 0);
        if (a >= 'h12 && a <= 'h1F) return m_bank[a - 'h12];
        return 0;
    endfunction

    task automatic compare(string tag);
        checks++;
        if (int'(irq_out) != m_pend) begin
            failures++;
            $display("FAIL %s irq actual=%0d expected=%0d", tag, irq_out, m_pend);
        end
        checks++;
        if (int'(bus_rdata) != model_read(int'(bus_addr))) begin
            failures++;
            $display("FAIL %s rdata@%0h actual=%0h expected=%0h", tag,
                     bus_addr, bus_rdata, model_read(int'(bus_addr)));
        end
    endtask

    task automatic model_reset();
        m_ctrl = 0;
        m_pend = 0;
        for (int i = 0; i < 14; i++) m_bank[i] = 0;
    endtask

    // one clock: drive at falling edge, compare, then advance model at rising edge
    task automatic step(string tag, bit wr, int a, int d, bit fe);
        int en_old;
        @(negedge clk);
        bus_wr    = wr;
        bus_addr  = 5'(a);
        bus_wdata = 8'(d);
        frame_end = fe;
        #0.5;
        compare(tag);
        @(posedge clk);
        en_old = (m_ctrl >> 7) & 1;
        if (wr && a == 'h10) m_ctrl = d & 'hFF;
        if (wr && a >= 'h12 && a <= 'h1F) m_bank[a - 'h12] = d & 'hFF;
        if (m_pend != 0) begin
            if (wr && a == 'h11) m_pend = 0;
        end else if (fe && en_old != 0) begin
            m_pend = 1;
        end
    endtask

    task automatic pulse_reset(string tag);
        @(negedge clk);
        rst_n = 1'b0;
        bus_wr = 1'b0;
        frame_end = 1'b0;
        model_reset();
        for (int k = 0; k < 2; k++) begin
            bus_addr = 5'h11;
            #0.5;
            compare(tag);
            @(negedge clk);
        end
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        model_reset();
        pulse_reset("R1");
        // R1 reset values across the map
        step("R1", 0, 'h10, 0, 0);
        step("R1", 0, 'h11, 0, 0);
        for (int a = 'h12; a <= 'h1F; a++) step("R1", 0, a, 0, 0);
        // R2 control byte
        step("R2", 1, 'h10, 'h5A, 0);
        step("R2", 0, 'h10, 0, 0);
        step("R2", 1, 'h10, 'hA5, 0);
        step("R2", 0, 'h10, 0, 0);
        // R3 bank bytes independent
        for (int a = 'h12; a <= 'h1F; a++) step("R3", 1, a, a * 17 + 3, 0);
        for (int a = 'h12; a <= 'h1F; a++) step("R3", 0, a, 0, 0);
        step("R3", 1, 'h17, 'h00, 0);
        for (int a = 'h12; a <= 'h1F; a++) step("R3", 0, a, 0, 0);
        // R9 holes read zero, writes ignored
        for (int a = 0; a < 'h10; a++) step("R9", 1, a, 'hFF, 0);
        for (int a = 0; a < 'h10; a++) step("R9", 0, a, 0, 0);
        step("R9", 0, 'h10, 0, 0);
        for (int a = 'h12; a <= 'h1F; a++) step("R9", 0, a, 0, 0);
        // R6 frame with enable clear
        step("R6", 1, 'h10, 'h7F, 0);
        step("R6", 0, 'h11, 0, 1);
        step("R6", 0, 'h11, 0, 1);
        step("R6", 0, 'h11, 0, 0);
        // R5 same-cycle control write uses old enable
        step("R5", 1, 'h10, 'h80, 1);
        step("R5", 0, 'h11, 0, 0);
        step("R5", 0, 'h11, 0, 1);
        step("R5", 0, 'h11, 0, 0);
        // R8 hold across frames and enable clear
        step("R8", 0, 'h11, 0, 1);
        step("R8", 1, 'h10, 'h00, 0);
        step("R8", 0, 'h11, 0, 1);
        step("R8", 0, 'h11, 0, 0);
        // R7 acknowledge
        step("R7", 1, 'h11, 'h00, 0);
        step("R7", 0, 'h11, 0, 0);
        step("R7", 1, 'h10, 'h80, 0);
        step("R7", 0, 'h11, 0, 1);
        step("R7", 1, 'h11, 'hFF, 1);
        step("R7", 0, 'h11, 0, 0);
        // R10 acknowledge while idle
        step("R10", 1, 'h11, 'hFF, 0);
        step("R10", 0, 'h11, 0, 0);
        step("R10", 1, 'h11, 'h00, 1);
        step("R10", 0, 'h11, 0, 0);
        // R4 status writes never alter constant bits
        step("R4", 1, 'h11, 'h00, 0);
        step("R4", 1, 'h11, 'h9E, 0);
        step("R4", 0, 'h11, 0, 0);
        step("R4", 0, 'h11, 0, 1);
        step("R4", 0, 'h11, 0, 0);
        // R1 reset while pending
        pulse_reset("R1");
        step("R1", 0, 'h10, 0, 0);
        step("R1", 0, 'h12, 0, 1);
        step("R1", 0, 'h11, 0, 0);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule